// File: doc/BRIEF.md
# CAN Bit Timing Logic

This block turns a stream of time-quantum enable pulses into the bit timing of a CAN node. Each nominal bit is one synchronisation quantum, then a first timing segment that ends at the sample point, then a second timing segment. The lengths of the two timing segments and the resynchronisation jump width come from a static configuration input.

After reset the block waits on an idle bus. The first recessive-to-dominant edge, or any such edge while the frame logic raises the hard-sync enable, restarts the bit so that the edge quantum becomes the synchronisation quantum. Any other falling edge shifts the sample point toward the transmitter's clock, at most once per bit: a late edge stretches the first segment and an early edge shortens the second. The block reports each sampled bus level with a one-cycle valid strobe. It also gives a transmit-point strobe at every synchronisation quantum, where the next transmit bit is launched.

Top module: `can_bit_timer`

## Requirements
- R1: A synchronous reset puts the block in bus idle with all strobes low. In idle, no strobe occurs until the first tick that sees a recessive-to-dominant edge.
- R2: Without edges, a bit lasts 1 + T1 + T2 ticks, where T1 = ts1_cfg + 1 (1..16), T2 = ts2_cfg + 1 (1..8) and SJW = sjw_cfg + 1 (1..4). The transmit point pulses at the synchronisation quantum, and the sample strobe pulses at the last quantum of the first segment.
- R3: sample_valid is a one-cycle pulse in the cycle after the sampling tick. sample_bit holds the rx_in level seen at that tick (1 = recessive).
- R4: A falling edge on a tick while hard_sync_en is high, or while idle, makes that quantum the synchronisation quantum. The transmit point pulses, and the next quantum is the first of segment 1. No further resynchronisation is allowed in that bit.
- R5: A falling edge at quantum k (1-based) of segment 1 lengthens segment 1 by min(k, SJW).
- R6: A falling edge at quantum j of segment 2 has error e = T2 - j + 1. Segment 2 is shortened by min(e, SJW). When e <= SJW, the edge quantum itself becomes the synchronisation quantum, with a transmit point and no further resynchronisation in that bit.
- R7: Only one resynchronisation is made per bit. A falling edge in the synchronisation quantum makes no adjustment.
- R8: A resynchronisation changes only the bit in which it occurs. The next bit uses the nominal lengths.
- R9: Edges are found by comparing rx_in with its level at the previous tick, and only recessive-to-dominant transitions count. Cycles with tq_en low change nothing and give no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tq_en | input | 1 | Time-quantum tick enable |
| ts1_cfg | input | 4 | Segment 1 length minus one |
| ts2_cfg | input | 3 | Segment 2 length minus one |
| sjw_cfg | input | 2 | Jump width minus one |
| hard_sync_en | input | 1 | Frame logic allows hard sync (start of frame) |
| rx_in | input | 1 | Bus level, 1 = recessive |
| sample_bit | output | 1 | Last sampled bus level |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| tx_point | output | 1 | One-cycle strobe at each synchronisation quantum |

## Verification
The hardest states to reach are the early-edge cases in segment 2, where the error is just above or just below the jump width. In one of them the edge quantum turns into the synchronisation quantum; in the other, the shortened segment ends on the same tick. The stimulus reaches them by toggling the bus at random moments with sparse, randomly gated ticks. It sweeps configurations that include the extreme lengths and jump widths, so that every error value meets every jump width many times. A bench model based on bit position predicts every strobe tick by tick.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tq_en,
  input  logic [TS1_W-1:0] ts1_cfg,
  input  logic [TS2_W-1:0] ts2_cfg,
  input  logic [SJW_W-1:0] sjw_cfg,
  input  logic             hard_sync_en,
  input  logic             rx_in,
  output logic             sample_bit,
  output logic             sample_valid,
  output logic             tx_point
);
  localparam int CW = TS1_W + 2;

  typedef enum logic [1:0] {IDLE, SYNC, SEG1, SEG2} seg_t;

  seg_t          seg, seg_n;
  logic [CW-1:0] cnt, cnt_n, lim, lim_n, lim_e;
  logic          used, used_n, prev_rx, smp, txp;

  wire [CW-1:0] t1   = CW'(ts1_cfg) + CW'(1);
  wire [CW-1:0] t2   = CW'(ts2_cfg) + CW'(1);
  wire [CW-1:0] sjw  = CW'(sjw_cfg) + CW'(1);
  wire          fall = tq_en & prev_rx & ~rx_in;
  wire          rsy  = fall & ~used;
  wire [CW-1:0] q    = cnt + CW'(1);
  wire [CW-1:0] err2 = lim - cnt;
  wire [CW-1:0] adj1 = (q < sjw) ? q : sjw;
  wire [CW-1:0] adj2 = (err2 < sjw) ? err2 : sjw;

  always_comb begin
    seg_n  = seg;
    cnt_n  = cnt;
    lim_n  = lim;
    used_n = used;
    lim_e  = lim;
    smp    = 1'b0;
    txp    = 1'b0;
    if (tq_en) begin
      if (fall && (seg == IDLE || hard_sync_en)) begin
        txp = 1'b1; seg_n = SEG1; cnt_n = '0; lim_n = t1; used_n = 1'b1;
      end else begin
        case (seg)
          SYNC: begin
            txp = 1'b1; seg_n = SEG1; cnt_n = '0; lim_n = t1; used_n = 1'b0;
          end
          SEG1: begin
            if (rsy) begin
              lim_e  = lim + adj1;
              used_n = 1'b1;
            end
            if (q == lim_e) begin
              smp = 1'b1; seg_n = SEG2; cnt_n = '0; lim_n = t2;
            end else begin
              cnt_n = q; lim_n = lim_e;
            end
          end
          SEG2: begin
            if (rsy) begin
              lim_e  = lim - adj2;
              used_n = 1'b1;
            end
            if (rsy && q > lim_e) begin
              txp = 1'b1; seg_n = SEG1; cnt_n = '0; lim_n = t1;
            end else if (q == lim_e) begin
              seg_n = SYNC; cnt_n = '0;
            end else begin
              cnt_n = q; lim_n = lim_e;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg          <= IDLE;
      cnt          <= '0;
      lim          <= '0;
      used         <= 1'b0;
      prev_rx      <= 1'b1;
      sample_bit   <= 1'b1;
      sample_valid <= 1'b0;
      tx_point     <= 1'b0;
    end else begin
      seg          <= seg_n;
      cnt          <= cnt_n;
      lim          <= lim_n;
      used         <= used_n;
      sample_valid <= smp;
      tx_point     <= txp;
      if (tq_en) prev_rx <= rx_in;
      if (smp) sample_bit <= rx_in;
    end
  end

  a_r2_count_in_segment: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG1 || seg == SEG2) |-> cnt < lim);
  a_r5_seg1_stretch_bound: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG1) |-> lim <= t1 + sjw);
  a_r6_seg2_never_longer: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG2) |-> lim <= t2);
  a_r9_no_tick_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !tq_en |=> !sample_valid && !tx_point);
  a_r3_strobes_apart: assert property (@(posedge clk) disable iff (rst)
    !(sample_valid && tx_point));
  a_r1_idle_silent: assert property (@(posedge clk) disable iff (rst)
    (seg == IDLE && !fall) |=> !tx_point && !sample_valid);
endmodule

// File: tb/can_bit_timer_tb.sv
module can_bit_timer_tb;
  logic       clk = 1'b0, rst = 1'b1, tq_en = 1'b0, hard_sync_en = 1'b0, rx_in = 1'b1;
  logic [3:0] ts1_cfg = '0;
  logic [2:0] ts2_cfg = '0;
  logic [1:0] sjw_cfg = '0;
  logic       sample_bit, sample_valid, tx_point;

  can_bit_timer u_dut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int T1, T2, SJW;
  int m_idle, m_p, m_ext, m_shr, m_used, m_prev, m_adj;
  bit e_valid, e_tx, e_bit;
  string tag;

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(string t, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", t, what, act, exp, cyc);
    end
  endtask

  task automatic model(bit tick, bit rx, bit hs);
    int cur, s1, e, m;
    bit f;
    e_valid = 0; e_tx = 0; tag = "R2";
    if (!tick) begin tag = "R9"; return; end
    f = m_prev && !rx;
    if (!m_prev && rx) tag = "R9";
    m_prev = rx;
    if (m_idle && !f) begin tag = "R1"; return; end
    if (f && (m_idle || hs)) begin
      tag = "R4"; e_tx = 1; m_idle = 0; m_p = 1; m_ext = 0; m_shr = 0; m_used = 1;
      return;
    end
    cur = m_p;
    s1  = T1 + m_ext;
    if (cur == 0) begin
      e_tx = 1; m_used = 0;
      if (m_adj) tag = "R8";
      if (f) tag = "R7";
      m_adj = 0;
    end else if (f && m_used) begin
      tag = "R7";
    end else if (f && cur <= s1) begin
      m_ext = imin(cur, SJW); m_used = 1; m_adj = 1; tag = "R5";
    end else if (f) begin
      e = s1 + T2 - cur + 1;
      m = imin(e, SJW);
      tag = "R6"; m_used = 1; m_adj = 1;
      if (m == e) begin
        e_tx = 1; m_p = 1; m_ext = 0; m_shr = 0;
        return;
      end
      m_shr = m;
    end
    s1 = T1 + m_ext;
    if (cur == s1) begin
      e_valid = 1; e_bit = rx;
      if (tag == "R2") tag = "R3";
    end
    m_p = cur + 1;
    if (m_p > s1 + T2 - m_shr) begin m_p = 0; m_ext = 0; m_shr = 0; end
  endtask

  task automatic do_reset(int a, int b, int c);
    @(negedge clk);
    rst = 1; tq_en = 0; hard_sync_en = 0; rx_in = 1;
    ts1_cfg = 4'(a); ts2_cfg = 3'(b); sjw_cfg = 2'(c);
    T1 = a + 1; T2 = b + 1; SJW = c + 1;
    m_idle = 1; m_p = 0; m_ext = 0; m_shr = 0; m_used = 0; m_prev = 1; m_adj = 0;
    e_valid = 0; e_tx = 0; tag = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1", "reset sample_valid", int'(sample_valid), 0);
    chk("R1", "reset tx_point", int'(tx_point), 0);
  endtask

  task automatic run(int n, int tick_pct, int tog_pct, int hs_pct);
    for (int i = 0; i < n; i++) begin
      bit t, r, h;
      t = ($urandom % 100) < tick_pct;
      r = (($urandom % 100) < tog_pct) ? ~rx_in : rx_in;
      h = ($urandom % 100) < hs_pct;
      tq_en = t; rx_in = r; hard_sync_en = h;
      model(t, r, h);
      @(negedge clk);
      chk(tag, "tx_point", int'(tx_point), int'(e_tx));
      chk(tag, "sample_valid", int'(sample_valid), int'(e_valid));
      if (e_valid) chk(tag, "sample_bit", int'(sample_bit), int'(e_bit));
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    // R1: idle with a quiet recessive bus stays silent
    do_reset(5, 3, 1);
    run(40, 100, 0, 0);
    run(2500, 70, 15, 10);
    do_reset(15, 7, 3);
    run(3000, 100, 10, 5);
    do_reset(0, 0, 0);
    run(3000, 80, 30, 10);
    do_reset(3, 2, 3);
    run(3000, 60, 20, 8);
    do_reset(7, 7, 0);
    run(3000, 100, 8, 3);
    for (int k = 0; k < 4; k++) begin
      do_reset($urandom % 16, $urandom % 8, $urandom % 4);
      run(3000, 50 + ($urandom % 51), 5 + ($urandom % 30), $urandom % 15);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule